// File: doc/BRIEF.md
# Per-Pin GPIO Control Slice with Overrides and Event Interrupts

This block controls a small bank of general-purpose pins. Each pin has a control word and a read-only status word, reached through a plain word-addressed write strobe and a registered read port. Each pin drives its pad either from a peripheral or from software output and output-enable registers, which are shared across the bank. Four independent two-bit override selectors can pass, invert, force low or force high the output, the output enable, the input and the interrupt. A per-pin pad word gates the input and the output driver.

Pad inputs are synchronized and then observed raw, through a short stability filter and through a longer debounce. Eight event types come from these three views: edges that latch and levels that follow the input. Each pin masks its events into one combined interrupt. A write-one-to-clear bit in the control word drops that pin's latched edges.

Address map (byte addresses, word aligned): pin n status at 8n, pin n control at 8n+4, software output word at 0x100, software output-enable word at 0x104, bank input word at 0x108 (input after override, one bit per pin), pin n pad word at 0x200+4n.

Top module: `gpio_pin_bank`

## Requirements
- R1: After reset, pad_out, pad_oe and irq are all 0. Every control word reads 0 and every pad word reads 0x40 (input enabled, driver allowed).
- R2: Pin n's control word at 8n+4 reads back what was written, except bit 28, which always reads 0. The pad word at 0x200+4n reads back bits 7:6.
- R3: Function code 5 in control bits 4:0 takes the output from bit n of the software output word and the enable from bit n of the software enable word. Any other code takes peri_out[n] and peri_oe[n]. Status bit 8 shows the chosen output and status bit 12 shows the chosen enable.
- R4: Control bits 13:12 set the output override: 0 passes the value, 1 inverts it, 2 forces 0, 3 forces 1. pad_out follows one clock after the control word changes, and status bit 9 shows the overridden value.
- R5: Control bits 15:14 apply the same four-way override to the output enable (2 disables, 3 enables). Status bit 13 shows the result.
- R6: Pad word bit 7 (output disable) holds pad_oe at 0 from the next clock onward. Pad word bit 6 (input enable) at 0 makes the synchronized input (status bit 17) read 0.
- R7: Control bits 17:16 apply the four-way override to the synchronized input. The result drives peri_in[n] and status bit 19.
- R8: Status bits 27:20 report, from bit 20 upward: falling edge, rising edge, level low, level high, filtered falling edge, filtered rising edge, debounced level low, debounced level high. Edge bits stay set until a control write with bit 28 = 1 clears them.
- R9: The level and debounced-level bits follow the current input and its debounced copy, and they need no clear.
- R10: The filtered input (status bit 18) takes a new value only after the synchronized input has held it for FILT_CYCLES clocks (default 4). The debounced copy needs DEB_CYCLES clocks (default 16). With the defaults, a 3-clock pulse is rejected and a 4-clock pulse is accepted.
- R11: The combined interrupt (status bit 28) is the OR of the events ANDed with mask bits 27:20. Control bits 31:30 apply the four-way override to it (status bit 29), and irq[n] is that value registered.
- R12: Pad inputs pass through two flip-flops before status bit 17 and all event logic see them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | AW | Byte address for writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the previous cycle's address |
| peri_out | input | NPINS | Peripheral output value per pin |
| peri_oe | input | NPINS | Peripheral output enable per pin |
| peri_in | output | NPINS | Input after override, to the peripheral |
| pad_in | input | NPINS | Raw pad input |
| pad_out | output | NPINS | Registered pad output value |
| pad_oe | output | NPINS | Registered pad driver enable |
| irq | output | NPINS | Registered per-pin interrupt after override |

## Verification
Read data is due one clock after the address is presented. pad_out, pad_oe and irq are due one clock after the register or event that feeds them. The raw input appears two clocks after a pad change. The filtered input appears FILT_CYCLES clocks after that, and the debounced copy DEB_CYCLES clocks after that. The filter boundary is checked by holding a status address steady and sampling on the exact falling edge before and after the expected change, at 6 and 7 clocks for the filter and 18 and 19 for the debounce. All other checks are made at falling edges, after waits that are longer than the worst-case latency.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam logic [4:0] FUNC_SOFT = 5'd5;

  typedef enum logic [1:0] {
    OVR_PASS = 2'd0,
    OVR_INV  = 2'd1,
    OVR_LOW  = 2'd2,
    OVR_HIGH = 2'd3
  } ovr_e;

  function automatic logic apply_ovr(input logic [1:0] sel, input logic v);
    case (ovr_e'(sel))
      OVR_PASS: return v;
      OVR_INV:  return ~v;
      OVR_LOW:  return 1'b0;
      default:  return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/gpio_stable_filter.sv
module gpio_stable_filter #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= 1'b0;
      cnt <= '0;
    end else if (d == q) begin
      cnt <= '0;
    end else if (cnt == CW'(CYCLES - 1)) begin
      q   <= d;
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/gpio_pin.sv
module gpio_pin
  import gpio_pkg::*;
#(
  parameter int FILT_CYCLES = 4,
  parameter int DEB_CYCLES  = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] ctrl,
  input  logic        clr_edges,
  input  logic        sw_out,
  input  logic        sw_oe,
  input  logic        peri_out,
  input  logic        peri_oe,
  input  logic        in_en,
  input  logic        out_dis,
  input  logic        pad_in,
  output logic        pad_out,
  output logic        pad_oe,
  output logic        peri_in,
  output logic        irq,
  output logic [31:0] status,
  output logic        sync_o,
  output logic        filt_o,
  output logic [3:0]  edge_o
);
  logic src_out, src_oe, out_ov, oe_ov, in_ov;
  logic s1, s2, prev_s, filt, prev_f, deb;
  logic [3:0] edge_q, edge_new;
  logic [7:0] events;
  logic comb, irq_ov;

  assign src_out = (ctrl[4:0] == FUNC_SOFT) ? sw_out : peri_out;
  assign src_oe  = (ctrl[4:0] == FUNC_SOFT) ? sw_oe  : peri_oe;
  assign out_ov  = apply_ovr(ctrl[13:12], src_out);
  assign oe_ov   = apply_ovr(ctrl[15:14], src_oe);

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= 1'b0;
      pad_oe  <= 1'b0;
      s1      <= 1'b0;
      s2      <= 1'b0;
      prev_s  <= 1'b0;
      prev_f  <= 1'b0;
    end else begin
      pad_out <= out_ov;
      pad_oe  <= oe_ov & ~out_dis;
      s1      <= pad_in & in_en;
      s2      <= s1;
      prev_s  <= s2;
      prev_f  <= filt;
    end
  end

  gpio_stable_filter #(.CYCLES(FILT_CYCLES)) u_filt (
    .clk(clk), .rst(rst), .d(s2), .q(filt)
  );
  gpio_stable_filter #(.CYCLES(DEB_CYCLES)) u_deb (
    .clk(clk), .rst(rst), .d(s2), .q(deb)
  );

  assign in_ov   = apply_ovr(ctrl[17:16], s2);
  assign peri_in = in_ov;

  // edge_q: 0 fall, 1 rise, 2 filtered fall, 3 filtered rise
  assign edge_new = {~prev_f & filt, prev_f & ~filt, ~prev_s & s2, prev_s & ~s2};

  always_ff @(posedge clk) begin
    if (rst) edge_q <= '0;
    else     edge_q <= (clr_edges ? 4'b0 : edge_q) | edge_new;
  end

  assign events = {deb, ~deb, edge_q[3], edge_q[2], s2, ~s2, edge_q[1], edge_q[0]};
  assign comb   = |(events & ctrl[27:20]);
  assign irq_ov = apply_ovr(ctrl[31:30], comb);

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_ov;
  end

  always_comb begin
    status        = '0;
    status[8]     = src_out;
    status[9]     = out_ov;
    status[12]    = src_oe;
    status[13]    = oe_ov;
    status[17]    = s2;
    status[18]    = filt;
    status[19]    = in_ov;
    status[27:20] = events;
    status[28]    = comb;
    status[29]    = irq_ov;
  end

  assign sync_o = s2;
  assign filt_o = filt;
  assign edge_o = edge_q;
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank #(
  parameter int NPINS       = 4,
  parameter int AW          = 10,
  parameter int FILT_CYCLES = 4,
  parameter int DEB_CYCLES  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] peri_out,
  input  logic [NPINS-1:0] peri_oe,
  output logic [NPINS-1:0] peri_in,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] irq
);
  localparam int          SW_BASE    = 256;
  localparam int          PAD_BASE   = 512;
  localparam logic [31:0] CTRL_WMASK = 32'hEFFF_FFFF;
  localparam logic [AW-1:0] A_SW_OUT = AW'(SW_BASE);
  localparam logic [AW-1:0] A_SW_OE  = AW'(SW_BASE + 4);
  localparam logic [AW-1:0] A_SW_IN  = AW'(SW_BASE + 8);

  logic [31:0]      ctrl_q   [NPINS];
  logic [31:0]      status_w [NPINS];
  logic [NPINS-1:0] pad_en_q, pad_dis_q, sw_out_q, sw_oe_q, clr_v;
  logic [NPINS-1:0] sync_v, filt_v, out_force_v, irq_low_v;
  logic [4*NPINS-1:0] edge_v;
  logic [31:0]      rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPINS; i++) ctrl_q[i] <= '0;
      pad_en_q  <= '1;
      pad_dis_q <= '0;
      sw_out_q  <= '0;
      sw_oe_q   <= '0;
    end else if (bus_wr) begin
      for (int i = 0; i < NPINS; i++) begin
        if (bus_addr == AW'(8 * i + 4)) ctrl_q[i] <= bus_wdata & CTRL_WMASK;
        if (bus_addr == AW'(PAD_BASE + 4 * i)) begin
          pad_en_q[i]  <= bus_wdata[6];
          pad_dis_q[i] <= bus_wdata[7];
        end
      end
      if (bus_addr == A_SW_OUT) sw_out_q <= bus_wdata[NPINS-1:0];
      if (bus_addr == A_SW_OE)  sw_oe_q  <= bus_wdata[NPINS-1:0];
    end
  end

  always_comb begin
    for (int i = 0; i < NPINS; i++)
      clr_v[i] = bus_wr && (bus_addr == AW'(8 * i + 4)) && bus_wdata[28];
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    gpio_pin #(.FILT_CYCLES(FILT_CYCLES), .DEB_CYCLES(DEB_CYCLES)) u_pin (
      .clk       (clk),
      .rst       (rst),
      .ctrl      (ctrl_q[g]),
      .clr_edges (clr_v[g]),
      .sw_out    (sw_out_q[g]),
      .sw_oe     (sw_oe_q[g]),
      .peri_out  (peri_out[g]),
      .peri_oe   (peri_oe[g]),
      .in_en     (pad_en_q[g]),
      .out_dis   (pad_dis_q[g]),
      .pad_in    (pad_in[g]),
      .pad_out   (pad_out[g]),
      .pad_oe    (pad_oe[g]),
      .peri_in   (peri_in[g]),
      .irq       (irq[g]),
      .status    (status_w[g]),
      .sync_o    (sync_v[g]),
      .filt_o    (filt_v[g]),
      .edge_o    (edge_v[4*g +: 4])
    );
    assign out_force_v[g] = (ctrl_q[g][13:12] == 2'b11);
    assign irq_low_v[g]   = (ctrl_q[g][31:30] == 2'b10);
  end

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (bus_addr == AW'(8 * i))            rd_next = status_w[i];
      if (bus_addr == AW'(8 * i + 4))        rd_next = ctrl_q[i];
      if (bus_addr == AW'(PAD_BASE + 4 * i)) rd_next = {24'b0, pad_dis_q[i], pad_en_q[i], 6'b0};
    end
    if (bus_addr == A_SW_OUT) rd_next = 32'(sw_out_q);
    if (bus_addr == A_SW_OE)  rd_next = 32'(sw_oe_q);
    if (bus_addr == A_SW_IN)  rd_next = 32'(peri_in);
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_next;
  end
endmodule

// File: rtl/gpio_pin_bank_chk.sv
module gpio_pin_bank_chk #(
  parameter int NPINS = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NPINS-1:0]   pad_oe,
  input logic [NPINS-1:0]   pad_out,
  input logic [NPINS-1:0]   irq,
  input logic [NPINS-1:0]   pad_dis_q,
  input logic [NPINS-1:0]   out_force_v,
  input logic [NPINS-1:0]   irq_low_v,
  input logic [NPINS-1:0]   sync_v,
  input logic [NPINS-1:0]   filt_v,
  input logic [NPINS-1:0]   clr_v,
  input logic [4*NPINS-1:0] edge_v
);
  AST_DRIVER_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & $past(pad_dis_q)) == '0); // R6

  AST_OUT_FORCED_HIGH: assert property (@(posedge clk) disable iff (rst)
    (pad_out & $past(out_force_v)) == $past(out_force_v)); // R4

  AST_IRQ_FORCED_LOW: assert property (@(posedge clk) disable iff (rst)
    (irq & $past(irq_low_v)) == '0); // R11

  AST_FILTER_TAKES_INPUT: assert property (@(posedge clk) disable iff (rst)
    ((filt_v ^ $past(filt_v)) & (filt_v ^ $past(sync_v))) == '0); // R10

  for (genvar g = 0; g < NPINS; g++) begin : g_hold
    AST_EDGE_HELD: assert property (@(posedge clk) disable iff (rst)
      (($past(edge_v[4*g +: 4]) & ~edge_v[4*g +: 4]) != 4'b0) |-> $past(clr_v[g])); // R8
  end
endmodule

bind gpio_pin_bank gpio_pin_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq),
  .pad_dis_q(pad_dis_q), .out_force_v(out_force_v), .irq_low_v(irq_low_v),
  .sync_v(sync_v), .filt_v(filt_v), .clr_v(clr_v), .edge_v(edge_v)
);

// File: tb/gpio_pin_bank_test.sv
module gpio_pin_bank_test;
  localparam int N = 4;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  peri_out = '0, peri_oe = '0, pad_in = '0;
  logic [N-1:0]  peri_in, pad_out, pad_oe, irq;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  gpio_pin_bank #(.NPINS(N), .AW(AW)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .peri_out(peri_out),
    .peri_oe(peri_oe), .peri_in(peri_in), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  function automatic logic ovr(input int sel, input logic v);
    case (sel)
      0: return v;
      1: return ~v;
      2: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] mk(input int func, input int osel, input int oesel,
                                     input int isel, input logic [7:0] mask,
                                     input logic clr, input int isel_irq);
    return {2'(isel_irq), 1'b0, clr, mask, 2'b0, 2'(isel), 2'(oesel), 2'(osel), 7'b0, 5'(func)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(a);
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic so, soe, eo, eoe, exp_in;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 pad_out", 32'(pad_out), 0);
    chk("R1 pad_oe", 32'(pad_oe), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(4, d);      chk("R1 ctrl0", d, 0);
    rd(512, d);    chk("R1 pad0", d, 32'h40);

    // R2 readback, bit 28 reads 0
    for (int p = 0; p < N; p++) begin
      wr(8*p+4, 32'h1F3A_0C02 ^ 32'(p));
      rd(8*p+4, d); chk("R2 ctrl readback", d, (32'h1F3A_0C02 ^ 32'(p)) & 32'hEFFF_FFFF);
      wr(512+4*p, 32'hC0);
      rd(512+4*p, d); chk("R2 pad readback", d, 32'hC0);
      wr(512+4*p, 32'h40);
      wr(8*p+4, 0);
    end

    // R3 R4 R5 R12 sweep over source, function and both overrides
    for (int p = 0; p < N; p++) begin
      for (int f = 0; f < 2; f++) begin
        for (int sv = 0; sv < 4; sv++) begin
          wr(256, sv[0] ? 32'hF : 32'h0);
          wr(260, sv[1] ? 32'hF : 32'h0);
          peri_out = sv[0] ? '0 : '1;
          peri_oe  = sv[1] ? '0 : '1;
          so  = (f == 1) ? sv[0] : ~sv[0];
          soe = (f == 1) ? sv[1] : ~sv[1];
          for (int os = 0; os < 4; os++) begin
            for (int es = 0; es < 4; es++) begin
              wr(8*p+4, mk(f == 1 ? 5 : 0, os, es, 0, 8'h00, 1'b0, 0));
              @(negedge clk);
              eo = ovr(os, so); eoe = ovr(es, soe);
              chk("R4 pad_out", 32'(pad_out[p]), 32'(eo));
              chk("R5 pad_oe", 32'(pad_oe[p]), 32'(eoe));
              rd(8*p, d);
              chk("R3 status src", {d[12], d[8]}, {soe, so});
              chk("R12 status ovr", {d[13], d[9]}, {eoe, eo});
            end
          end
        end
      end
    end
    peri_out = '0; peri_oe = '0;

    // R6 pad gating
    wr(4, mk(5, 3, 3, 0, 8'h00, 1'b0, 0));
    idle(2);
    chk("R6 oe allowed", 32'(pad_oe[0]), 1);
    wr(512, 32'hC0);
    @(negedge clk);
    chk("R6 oe blocked", 32'(pad_oe[0]), 0);
    chk("R6 out unaffected", 32'(pad_out[0]), 1);
    wr(512, 32'h00);
    pad_in = '1;
    idle(5);
    rd(0, d); chk("R6 input disabled", 32'(d[17]), 0);
    wr(512, 32'h40);
    idle(3);
    rd(0, d); chk("R12 input enabled", 32'(d[17]), 1);
    pad_in = '0;
    idle(30);

    // R7 input override
    for (int is = 0; is < 4; is++) begin
      for (int v = 0; v < 2; v++) begin
        pad_in[1] = v[0];
        idle(4);
        wr(12, mk(0, 0, 0, is, 8'h00, 1'b0, 0));
        @(negedge clk);
        exp_in = ovr(is, v[0]);
        chk("R7 peri_in", 32'(peri_in[1]), 32'(exp_in));
        rd(8, d);
        chk("R7 status", {d[19], d[17]}, {exp_in, v[0]});
        rd(264, d);
        chk("R7 bank in word bit", 32'(d[1]), 32'(exp_in));
      end
    end
    pad_in[1] = 1'b0;
    idle(30);

    // R8 R9 event order, latching and clearing on pin 2
    wr(20, mk(0, 0, 0, 0, 8'h00, 1'b1, 0));
    rd(16, d); chk("R9 idle low levels", 32'(d[27:20]), 32'h44);
    pad_in[2] = 1'b1; idle(40);
    rd(16, d); chk("R8 rise events", 32'(d[27:20]), 32'hAA);
    pad_in[2] = 1'b0; idle(40);
    rd(16, d); chk("R8 both edges held", 32'(d[27:20]), 32'h77);
    idle(10);
    rd(16, d); chk("R8 still held", 32'(d[27:20]), 32'h77);
    wr(20, mk(0, 0, 0, 0, 8'h00, 1'b1, 0));
    rd(16, d); chk("R8 cleared", 32'(d[27:20]), 32'h44);

    // R10 filter and debounce timing on pin 3
    wr(28, mk(0, 0, 0, 0, 8'h00, 1'b1, 0));
    @(negedge clk);
    bus_addr = AW'(24);
    @(negedge clk);
    pad_in[3] = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 filter not yet", 32'(bus_rdata[18]), 0);
    @(negedge clk);
    chk("R10 filter taken", 32'(bus_rdata[18]), 1);
    repeat (11) @(negedge clk);
    chk("R10 debounce not yet", 32'(bus_rdata[27]), 0);
    @(negedge clk);
    chk("R10 debounce taken", 32'(bus_rdata[27]), 1);
    pad_in[3] = 1'b0; idle(40);
    wr(28, mk(0, 0, 0, 0, 8'h00, 1'b1, 0));
    pad_in[3] = 1'b1; idle(3); pad_in[3] = 1'b0;
    idle(20);
    rd(24, d);
    chk("R10 short pulse rejected", 32'(d[25]), 0);
    chk("R8 short pulse raw edge", 32'(d[21]), 1);
    wr(28, mk(0, 0, 0, 0, 8'h00, 1'b1, 0));
    pad_in[3] = 1'b1; idle(4); pad_in[3] = 1'b0;
    idle(20);
    rd(24, d);
    chk("R10 four clock pulse accepted", 32'(d[25]), 1);

    // R11 interrupt mask and override on pin 0
    wr(4, mk(0, 0, 0, 0, 8'h02, 1'b1, 0));
    idle(3);
    chk("R11 no event", 32'(irq[0]), 0);
    pad_in[0] = 1'b1; idle(10);
    chk("R11 rise unmasked", 32'(irq[0]), 1);
    rd(0, d); chk("R11 combined status", {d[29], d[28]}, 2'b11);
    wr(4, mk(0, 0, 0, 0, 8'h01, 1'b0, 0));
    idle(2);
    chk("R11 rise masked off", 32'(irq[0]), 0);
    wr(4, mk(0, 0, 0, 0, 8'h01, 1'b0, 1));
    idle(2);
    chk("R11 inverted", 32'(irq[0]), 1);
    wr(4, mk(0, 0, 0, 0, 8'h00, 1'b0, 3));
    idle(2);
    chk("R11 forced high", 32'(irq[0]), 1);
    wr(4, mk(0, 0, 0, 0, 8'hFF, 1'b0, 2));
    idle(2);
    chk("R11 forced low", 32'(irq[0]), 0);
    wr(4, mk(0, 0, 0, 0, 8'h08, 1'b1, 0));
    idle(2);
    chk("R9 level high irq", 32'(irq[0]), 1);
    pad_in[0] = 1'b0; idle(5);
    chk("R9 level follows input", 32'(irq[0]), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule